// File: doc/BRIEF.md
# Partial Frame Checksum Offload Engine

This block does partial checksum offload for byte-wide frame streams. It computes a 16-bit ones-complement sum and has two independent paths. The transmit path takes three values with each frame: a start offset, an insert offset and a 16-bit seed. It holds the whole frame in a buffer and sums the seed plus every byte from the start offset to the final byte. It then sends the frame out again with the complemented sum written at the insert offset, so protocol software only has to set up the pseudo-header seed and the positions.

The receive path forwards frames unchanged. Alongside each frame it computes the uncomplemented sum of everything from byte offset 14 to the end of the frame, which is the entire payload of an untagged frame. It returns that sum on a status channel with its own valid/ready handshake. Software then removes anything it did not want counted, such as a trailing FCS or short-frame padding that was not stripped.

Top module: `csum_offload_top`

## Requirements
- R1: After reset, `tx_out_valid` and `rx_sts_valid` are low and `tx_in_ready` is high; `rx_in_ready` is high whenever `rx_out_ready` is high.
- R2: The transmit output is the input frame, with the same length and `tx_out_last` on its final byte. The bytes at the insert offset (high half) and at insert offset + 1 (low half) are replaced by the bitwise complement of the ones-complement sum. That sum is built with end-around carry from the seed and the bytes from the start offset through the last byte. Bytes pair big-endian relative to the start offset: the first summed byte is a high half and an odd trailing byte has a zero low half. Summed bytes always use their original values, even when the insert field lies inside the summed range or before the start.
- R3: Start offset, insert offset and seed are taken only with the first accepted byte of a frame; values presented on later bytes have no effect.
- R4: A transmit frame whose start offset is at or beyond its length leaves the engine unchanged.
- R5: A transmit frame whose insert offset plus 2 exceeds its length leaves the engine unchanged.
- R6: The transmit path is store-and-forward. No output byte appears until the last input byte has been accepted. `tx_in_ready` stays low from then until the last output byte is accepted. Frames of up to `MAX_LEN` bytes are supported.
- R7: While `tx_out_valid` is high and `tx_out_ready` is low, the output byte and last flag hold.
- R8: Receive bytes pass straight through: `rx_out_data` and `rx_out_last` equal the input, and an input byte is taken only when `rx_out_ready` is high.
- R9: The receive status value is the uncomplemented ones-complement sum, starting from zero, of bytes from offset 14 to the frame's last byte. Offset 14 is a high half. Any trailing FCS or pad bytes that are present are included.
- R10: `rx_sts_valid` rises in the cycle after a frame's last byte is accepted. It and `rx_sts_sum` then hold until `rx_sts_ready` is sampled high. While the status is pending, `rx_in_ready` is low.
- R11: A receive frame of 14 bytes or fewer reports a sum of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_last | input | 1 | Final byte of the transmit frame |
| tx_in_ready | output | 1 | Transmit input accepted |
| tx_start_off | input | OFF_W | Offset of the first summed byte (first beat) |
| tx_insert_off | input | OFF_W | Offset of the checksum's high byte (first beat) |
| tx_seed | input | 16 | Initial sum value (first beat) |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_last | output | 1 | Final byte of the transmit output frame |
| tx_out_ready | input | 1 | Downstream accepts a transmit byte |
| rx_in_data | input | 8 | Receive input byte |
| rx_in_valid | input | 1 | Receive input byte valid |
| rx_in_last | input | 1 | Final byte of the receive frame |
| rx_in_ready | output | 1 | Receive input accepted |
| rx_out_data | output | 8 | Forwarded receive byte |
| rx_out_valid | output | 1 | Forwarded receive byte valid |
| rx_out_last | output | 1 | Forwarded final byte |
| rx_out_ready | input | 1 | Downstream accepts a receive byte |
| rx_sts_sum | output | 16 | Receive payload sum |
| rx_sts_valid | output | 1 | Receive status valid |
| rx_sts_ready | input | 1 | Status consumer ready |

## Verification
Random transmit frames of 1 to 64 bytes use random offsets and seeds. They are mixed with directed frames that separate the pairing rules:
- an odd start offset, which checks that pairing follows the start and not absolute parity;
- an odd length, which exercises the zero-padded trailing half;
- an insert field that lies before the start, and one inside the summed range, which show whether original or patched bytes are summed;
- start at or past the end, and insert at length - 1, which must leave the frame unchanged;
- a frame of full buffer length.

Receive frames of 10, 14, 15 and random longer lengths separate the fixed offset 14 from an off-by-one start and show the empty-range result. Random downstream readiness on both paths exposes any loss of hold under backpressure.

// File: rtl/csum_pkg.sv
package csum_pkg;

    localparam int CSUM_W = 16;

    typedef logic [7:0]        byte_t;
    typedef logic [CSUM_W-1:0] csum_t;

    typedef enum logic {
        TX_FILL  = 1'b0,
        TX_DRAIN = 1'b1
    } tx_state_e;

    typedef struct packed {
        byte_t data;
        logic  last;
    } beat_t;

    // ones-complement addition with end-around carry
    function automatic csum_t oc_add(csum_t a, csum_t b);
        logic [CSUM_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
    endfunction

    // place a byte in the high or low half of a 16-bit word
    function automatic csum_t lane(byte_t b, logic hi);
        return hi ? {b, 8'h00} : {8'h00, b};
    endfunction

endpackage

// File: rtl/csum_frame_buf.sv
module csum_frame_buf import csum_pkg::*; #(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  byte_t         wr_data,
    input  logic [AW-1:0] rd_addr,
    output byte_t         rd_data
);

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/csum_tx_engine.sv
module csum_tx_engine import csum_pkg::*; #(
    parameter  int MAX_LEN = 256,
    localparam int OFF_W   = $clog2(MAX_LEN),
    localparam int LEN_W   = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_t            in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    input  logic [OFF_W-1:0] start_off,
    input  logic [OFF_W-1:0] ins_off,
    input  csum_t            seed,
    output byte_t            out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready
);

    tx_state_e        state;
    logic [LEN_W-1:0] wr_idx, rd_idx, len_q, frame_len;
    logic [OFF_W-1:0] start_q, ins_q, cur_start, cur_ins;
    csum_t            acc, acc_base, acc_next, csum_q;
    logic             apply_q, first, in_range, take, fits;
    logic             at_hi, at_lo;
    byte_t            buf_byte;
    beat_t            ob;

    assign in_ready  = (state == TX_FILL);
    assign take      = in_valid && in_ready;
    assign first     = (wr_idx == '0);
    assign cur_start = first ? start_off : start_q;
    assign cur_ins   = first ? ins_off   : ins_q;
    assign acc_base  = first ? seed      : acc;
    assign in_range  = (wr_idx >= {1'b0, cur_start});
    // pairing is relative to the start offset
    assign acc_next  = in_range ? oc_add(acc_base, lane(in_data, ~(wr_idx[0] ^ cur_start[0])))
                                : acc_base;
    assign frame_len = wr_idx + 1'b1;
    assign fits      = ({1'b0, cur_start} < frame_len) &&
                       (({2'b00, cur_ins} + (LEN_W+1)'(2)) <= {1'b0, frame_len});

    csum_frame_buf #(.DEPTH(MAX_LEN)) i_buf (
        .clk     (clk),
        .wr_en   (take),
        .wr_addr (wr_idx[OFF_W-1:0]),
        .wr_data (in_data),
        .rd_addr (rd_idx[OFF_W-1:0]),
        .rd_data (buf_byte)
    );

    assign at_hi = apply_q && (rd_idx == {1'b0, ins_q});
    assign at_lo = apply_q && (rd_idx == ({1'b0, ins_q} + 1'b1));

    always_comb begin
        ob.data = buf_byte;
        if (at_hi)      ob.data = csum_q[15:8];
        else if (at_lo) ob.data = csum_q[7:0];
        ob.last = (rd_idx == (len_q - 1'b1));
    end

    assign out_valid = (state == TX_DRAIN);
    assign out_data  = ob.data;
    assign out_last  = ob.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_FILL;
            wr_idx  <= '0;
            rd_idx  <= '0;
            len_q   <= '0;
            start_q <= '0;
            ins_q   <= '0;
            acc     <= '0;
            csum_q  <= '0;
            apply_q <= 1'b0;
        end else begin
            case (state)
                TX_FILL: if (take) begin
                    acc <= acc_next;
                    if (first) begin
                        start_q <= start_off;
                        ins_q   <= ins_off;
                    end
                    if (in_last) begin
                        len_q   <= frame_len;
                        csum_q  <= ~acc_next;
                        apply_q <= fits;
                        wr_idx  <= '0;
                        rd_idx  <= '0;
                        state   <= TX_DRAIN;
                    end else begin
                        wr_idx  <= wr_idx + 1'b1;
                    end
                end
                TX_DRAIN: if (out_ready) begin
                    if (ob.last) begin
                        rd_idx <= '0;
                        state  <= TX_FILL;
                    end else begin
                        rd_idx <= rd_idx + 1'b1;
                    end
                end
                default: state <= TX_FILL;
            endcase
        end
    end

endmodule

// File: rtl/csum_rx_engine.sv
module csum_rx_engine import csum_pkg::*; #(
    parameter  int SUM_START = 14,
    localparam int CW        = $clog2(SUM_START + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  byte_t in_data,
    input  logic  in_valid,
    input  logic  in_last,
    output logic  in_ready,
    output byte_t out_data,
    output logic  out_valid,
    output logic  out_last,
    input  logic  out_ready,
    output csum_t sts_sum,
    output logic  sts_valid,
    input  logic  sts_ready
);

    logic [CW-1:0] hdr_cnt;
    logic          phase, in_range, take;
    csum_t         acc, acc_next;

    assign in_ready  = out_ready && !sts_valid;
    assign out_valid = in_valid && !sts_valid;
    assign out_data  = in_data;
    assign out_last  = in_last;
    assign take      = in_valid && in_ready;
    assign in_range  = (hdr_cnt == CW'(SUM_START));
    assign acc_next  = in_range ? oc_add(acc, lane(in_data, ~phase)) : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_cnt   <= '0;
            phase     <= 1'b0;
            acc       <= '0;
            sts_sum   <= '0;
            sts_valid <= 1'b0;
        end else begin
            if (sts_valid && sts_ready) sts_valid <= 1'b0;
            if (take) begin
                if (in_last) begin
                    sts_sum   <= acc_next;
                    sts_valid <= 1'b1;
                    hdr_cnt   <= '0;
                    phase     <= 1'b0;
                    acc       <= '0;
                end else begin
                    acc <= acc_next;
                    if (in_range) phase   <= ~phase;
                    else          hdr_cnt <= hdr_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/csum_offload_top.sv
module csum_offload_top import csum_pkg::*; #(
    parameter  int MAX_LEN   = 256,
    parameter  int RX_START  = 14,
    localparam int OFF_W     = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       tx_in_data,
    input  logic             tx_in_valid,
    input  logic             tx_in_last,
    output logic             tx_in_ready,
    input  logic [OFF_W-1:0] tx_start_off,
    input  logic [OFF_W-1:0] tx_insert_off,
    input  logic [15:0]      tx_seed,
    output logic [7:0]       tx_out_data,
    output logic             tx_out_valid,
    output logic             tx_out_last,
    input  logic             tx_out_ready,
    input  logic [7:0]       rx_in_data,
    input  logic             rx_in_valid,
    input  logic             rx_in_last,
    output logic             rx_in_ready,
    output logic [7:0]       rx_out_data,
    output logic             rx_out_valid,
    output logic             rx_out_last,
    input  logic             rx_out_ready,
    output logic [15:0]      rx_sts_sum,
    output logic             rx_sts_valid,
    input  logic             rx_sts_ready
);

    csum_tx_engine #(.MAX_LEN(MAX_LEN)) i_tx (
        .clk       (clk),
        .rst       (rst),
        .in_data   (tx_in_data),
        .in_valid  (tx_in_valid),
        .in_last   (tx_in_last),
        .in_ready  (tx_in_ready),
        .start_off (tx_start_off),
        .ins_off   (tx_insert_off),
        .seed      (tx_seed),
        .out_data  (tx_out_data),
        .out_valid (tx_out_valid),
        .out_last  (tx_out_last),
        .out_ready (tx_out_ready)
    );

    csum_rx_engine #(.SUM_START(RX_START)) i_rx (
        .clk       (clk),
        .rst       (rst),
        .in_data   (rx_in_data),
        .in_valid  (rx_in_valid),
        .in_last   (rx_in_last),
        .in_ready  (rx_in_ready),
        .out_data  (rx_out_data),
        .out_valid (rx_out_valid),
        .out_last  (rx_out_last),
        .out_ready (rx_out_ready),
        .sts_sum   (rx_sts_sum),
        .sts_valid (rx_sts_valid),
        .sts_ready (rx_sts_ready)
    );

endmodule

// File: rtl/csum_offload_chk.sv
module csum_offload_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_in_valid,
    input logic        tx_in_ready,
    input logic        tx_in_last,
    input logic [7:0]  tx_out_data,
    input logic        tx_out_valid,
    input logic        tx_out_last,
    input logic        tx_out_ready,
    input logic        rx_in_valid,
    input logic        rx_in_ready,
    input logic        rx_in_last,
    input logic [15:0] rx_sts_sum,
    input logic        rx_sts_valid,
    input logic        rx_sts_ready
);

    // R6
    tx_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        tx_out_valid |-> !tx_in_ready);

    // R6
    tx_drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && tx_in_ready && tx_in_last) |=> tx_out_valid);

    // R7
    tx_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_out_valid && !tx_out_ready) |=>
            (tx_out_valid && $stable(tx_out_data) && $stable(tx_out_last)));

    // R10
    rx_sts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_in_valid && rx_in_ready && rx_in_last) |=> rx_sts_valid);

    // R10
    rx_sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_sts_valid && !rx_sts_ready) |=> (rx_sts_valid && $stable(rx_sts_sum)));

    // R10
    rx_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        rx_sts_valid |-> !rx_in_ready);

endmodule

bind csum_offload_top csum_offload_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_in_valid  (tx_in_valid),
    .tx_in_ready  (tx_in_ready),
    .tx_in_last   (tx_in_last),
    .tx_out_data  (tx_out_data),
    .tx_out_valid (tx_out_valid),
    .tx_out_last  (tx_out_last),
    .tx_out_ready (tx_out_ready),
    .rx_in_valid  (rx_in_valid),
    .rx_in_ready  (rx_in_ready),
    .rx_in_last   (rx_in_last),
    .rx_sts_sum   (rx_sts_sum),
    .rx_sts_valid (rx_sts_valid),
    .rx_sts_ready (rx_sts_ready)
);

// File: tb/test_csum_offload_top.sv
module test_csum_offload_top;

    localparam int MAX_LEN = 256;
    localparam int OFF_W   = $clog2(MAX_LEN);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       tx_in_data = '0;
    logic             tx_in_valid = 1'b0, tx_in_last = 1'b0, tx_in_ready;
    logic [OFF_W-1:0] tx_start_off = '0, tx_insert_off = '0;
    logic [15:0]      tx_seed = '0;
    logic [7:0]       tx_out_data;
    logic             tx_out_valid, tx_out_last, tx_out_ready = 1'b0;
    logic [7:0]       rx_in_data = '0;
    logic             rx_in_valid = 1'b0, rx_in_last = 1'b0, rx_in_ready;
    logic [7:0]       rx_out_data;
    logic             rx_out_valid, rx_out_last, rx_out_ready = 1'b0;
    logic [15:0]      rx_sts_sum;
    logic             rx_sts_valid, rx_sts_ready = 1'b0;

    int errors = 0;
    int checks = 0;

    logic [7:0] fr  [MAX_LEN];
    logic [7:0] exq [MAX_LEN];

    always #10 clk = ~clk;

    csum_offload_top #(.MAX_LEN(MAX_LEN)) i_csum_offload_top (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] oc(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction

    task automatic fill(input int len);
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    endtask

    task automatic tx_run(input int len, input int st, input int ins,
                          input logic [15:0] seed, input string req);
        logic [15:0] s, ck;
        int got;
        bit hold, r;
        logic [7:0] held;
        s = seed;
        for (int i = st; i < len; i++)
            s = oc(s, ((i - st) % 2 == 0) ? {fr[i], 8'h00} : {8'h00, fr[i]});
        ck = ~s;
        for (int i = 0; i < len; i++) exq[i] = fr[i];
        if (st < len && ins + 2 <= len) begin
            exq[ins]     = ck[15:8];
            exq[ins + 1] = ck[7:0];
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_in_valid = 1'b1;
            tx_in_data  = fr[i];
            tx_in_last  = (i == len - 1);
            // R3: later beats carry unrelated sideband values
            tx_start_off  = (i == 0) ? OFF_W'(st)  : OFF_W'($urandom);
            tx_insert_off = (i == 0) ? OFF_W'(ins) : OFF_W'($urandom);
            tx_seed       = (i == 0) ? seed        : 16'($urandom);
            #1;
            while (!tx_in_ready) begin
                @(negedge clk);
                #1;
            end
            chk(!tx_out_valid, "R6 no output during fill", tx_out_valid, 0);
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_last  = 1'b0;
        #1;
        chk(!tx_in_ready, "R6 input blocked during drain", tx_in_ready, 0);
        got  = 0;
        hold = 0;
        held = '0;
        while (got < len) begin
            r = ($urandom % 3) != 0;
            tx_out_ready = r;
            #1;
            if (hold)
                chk(tx_out_valid && tx_out_data == held, "R7 hold", tx_out_data, held);
            if (tx_out_valid && r) begin
                chk(tx_out_data == exq[got], req, tx_out_data, exq[got]);
                chk(tx_out_last == (got == len - 1), "R2 last flag", tx_out_last, got == len - 1);
                got++;
                hold = 0;
            end else if (tx_out_valid) begin
                hold = 1;
                held = tx_out_data;
            end
            @(negedge clk);
        end
        tx_out_ready = 1'b0;
        #1;
        chk(!tx_out_valid && tx_in_ready, "R6 back to fill", tx_out_valid, 0);
    endtask

    task automatic rx_run(input int len);
        logic [15:0] s;
        s = '0;
        for (int i = 14; i < len; i++)
            s = oc(s, ((i - 14) % 2 == 0) ? {fr[i], 8'h00} : {8'h00, fr[i]});
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_in_valid = 1'b1;
            rx_in_data  = fr[i];
            rx_in_last  = (i == len - 1);
            rx_out_ready = 1'($urandom % 2);
            #1;
            while (!rx_in_ready) begin
                @(negedge clk);
                rx_out_ready = 1'($urandom % 2);
                #1;
            end
            chk(rx_out_valid && rx_out_data == fr[i] && rx_out_last == (i == len - 1),
                "R8 pass-through", rx_out_data, fr[i]);
        end
        @(negedge clk);
        rx_in_valid  = 1'b0;
        rx_in_last   = 1'b0;
        rx_out_ready = 1'b1;
        #1;
        chk(rx_sts_valid, "R10 status next cycle", rx_sts_valid, 1);
        // R11 covers the short-frame case through the same expected model
        chk(rx_sts_sum == s, (len <= 14) ? "R11 short sum" : "R9 payload sum", rx_sts_sum, s);
        @(negedge clk);
        #1;
        chk(rx_sts_valid && rx_sts_sum == s, "R10 status held", rx_sts_sum, s);
        chk(!rx_in_ready, "R10 input blocked", rx_in_ready, 0);
        rx_sts_ready = 1'b1;
        @(negedge clk);
        rx_sts_ready = 1'b0;
        #1;
        chk(!rx_sts_valid && rx_in_ready, "R10 status consumed", rx_sts_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c5_0ff1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rx_out_ready = 1'b1;
        #1;
        chk(!tx_out_valid && !rx_sts_valid && tx_in_ready && rx_in_ready,
            "R1 reset state", {tx_out_valid, rx_sts_valid, tx_in_ready, rx_in_ready}, 4'b0011);

        // directed transmit corner cases
        fill(20); tx_run(20, 0, 0, 16'h0000, "R2 even start at 0");
        fill(21); tx_run(21, 3, 18, 16'h1234, "R2 odd start odd length");
        fill(30); tx_run(30, 14, 2, 16'hffff, "R2 insert before start");
        fill(30); tx_run(30, 10, 16, 16'h8001, "R2 insert inside range");
        fill(12); tx_run(12, 12, 0, 16'h4321, "R4 start at length");
        fill(12); tx_run(12, 40, 0, 16'h4321, "R4 start past length");
        fill(12); tx_run(12, 0, 11, 16'h0f0f, "R5 insert at length-1");
        fill(12); tx_run(12, 0, 10, 16'h0f0f, "R5 insert fits exactly");
        fill(1);  tx_run(1, 0, 0, 16'h00aa, "R5 single byte");
        fill(MAX_LEN); tx_run(MAX_LEN, 7, 200, 16'h5555, "R6 full length");

        // random transmit frames, sideband varied after the first beat (R3)
        for (int n = 0; n < 25; n++) begin
            int len;
            len = 1 + ($urandom % 64);
            fill(len);
            tx_run(len, $urandom % 70, $urandom % 70, 16'($urandom), "R3 R2 random frame");
        end

        // receive: short, boundary and random frames
        fill(10); rx_run(10);
        fill(14); rx_run(14);
        fill(15); rx_run(15);
        fill(64); rx_run(64);
        for (int n = 0; n < 15; n++) begin
            int len;
            len = 1 + ($urandom % 80);
            fill(len);
            rx_run(len);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule